// File: doc/BRIEF.md
# Slow-Tick Counter Display Selector

This block drives eight indicator LEDs from a fast system clock (nominally 1 MHz) so that a slowly changing pattern can be watched by eye. A free-running divider produces a single-cycle enable pulse once every 32768 clocks, about 30.5 Hz at 1 MHz. No second clock is derived from it. On each pulse an eight-bit reference counter advances by one. The reference counter is cleared by the block reset.

The LEDs show one of two views. The register view shows an eight-bit value that arrives from outside the block, for example the contents of a pseudorandom shift register. The counter view shows the upper seven bits of the reference counter on LED[7:1]. In that view LED[0] shows an outside flag that marks when the watched register sits in its reset state. Comparing the flag against the counter lets a user time the period of the watched register. A push button flips between the two views on each press.

Top module: `slow_tick_display`

## Requirements
- R1: The divider is a free-running DIV_W-bit (default 16) counter cleared by reset. `tick_o` is high in exactly those cycles where its low TICK_LOG2 (default 15) bits are all one. After reset is released, the first tick therefore appears in the cycle after 2^TICK_LOG2−1 rising edges, and each later tick follows 2^TICK_LOG2 cycles after the previous one.
- R2: `tick_o` is never high in two consecutive cycles.
- R3: The reference counter is LED_W bits wide. It increments by one, modulo 2^LED_W, on each rising edge where the tick is high, and holds its value on every other edge.
- R4: A synchronous, active-high `rst` clears the divider, clears the reference counter and selects the register view. Clearing takes priority over an increment when a tick falls in the same cycle.
- R5: In the counter view (mode bit 1), `led_o[LED_W-1:1]` equals reference counter bits [LED_W-1:1], and `led_o[0]` equals `seed_flag_i`.
- R6: In the register view (mode bit 0), `led_o` equals `reg_val_i` bit for bit.
- R7: The button input is registered once. The view toggles only on a rising edge of `mode_btn_i`, meaning the button is 1 now and was 0 on the previous edge. Holding the button or releasing it leaves the view unchanged.
- R8: While reset is held, `led_o` follows `reg_val_i` and `tick_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high clear of divider, counter and view |
| mode_btn_i | input | 1 | View select button, toggles on rising edge |
| seed_flag_i | input | 1 | Outside flag: watched register is at its reset state |
| reg_val_i | input | LED_W | Outside register value shown in the register view |
| led_o | output | LED_W | LED drive |
| tick_o | output | 1 | One-cycle enable pulse from the divider |

## Verification
The assertions assume that `rst`, `mode_btn_i` and the data inputs are driven synchronously and hold known values on every edge once reset has been applied. They also assume that reset is asserted before any other edge matters. The bench changes inputs only at falling clock edges and holds reset high for several edges at start-up. It presses the button for several cycles at a time, so hold-without-retoggle is exercised. A reduced-divider instance is swept through a full counter wrap, and a reset is placed exactly on a tick cycle.

// File: rtl/std_disp_pkg.sv
package std_disp_pkg;

    typedef enum logic {
        MODE_REG = 1'b0,
        MODE_CNT = 1'b1
    } disp_mode_e;

    typedef struct packed {
        logic       btn;
        disp_mode_e mode;
    } toggle_state_t;

endpackage

// File: rtl/std_tick_divider.sv
module std_tick_divider #(
    parameter int DIV_W     = 16,
    parameter int TICK_LOG2 = 15
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + ONE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // decode of the low field, used as an enable only
    assign tick_o = &st_q.div[TICK_LOG2-1:0];

endmodule

// File: rtl/std_ref_counter.sv
module std_ref_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = '0;          // clear wins over the tick
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/std_mode_toggle.sv
module std_mode_toggle
    import std_disp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_i,
    output disp_mode_e mode_o
);
    toggle_state_t st_d, st_q;
    logic          press;

    assign press = btn_i & ~st_q.btn;

    always_comb begin
        st_d     = st_q;
        st_d.btn = btn_i;           // sampled in reset too, so no edge on release
        if (rst) begin
            st_d.mode = MODE_REG;
        end else if (press) begin
            st_d.mode = (st_q.mode == MODE_REG) ? MODE_CNT : MODE_REG;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode_o = st_q.mode;

endmodule

// File: rtl/std_led_mux.sv
module std_led_mux
    import std_disp_pkg::*;
#(
    parameter int LED_W = 8
) (
    input  disp_mode_e       mode_i,
    input  logic [LED_W-2:0] cnt_hi_i,
    input  logic             seed_i,
    input  logic [LED_W-1:0] reg_i,
    output logic [LED_W-1:0] led_o
);
    logic sel_cnt;

    assign sel_cnt = (mode_i == MODE_CNT);

    for (genvar i = 0; i < LED_W; i++) begin : g_bit
        if (i == 0) begin : g_flag
            assign led_o[i] = sel_cnt ? seed_i : reg_i[i];
        end else begin : g_cnt
            assign led_o[i] = sel_cnt ? cnt_hi_i[i-1] : reg_i[i];
        end
    end

endmodule

// File: rtl/slow_tick_display.sv
module slow_tick_display
    import std_disp_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int TICK_LOG2 = 15,
    parameter int LED_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_btn_i,
    input  logic             seed_flag_i,
    input  logic [LED_W-1:0] reg_val_i,
    output logic [LED_W-1:0] led_o,
    output logic             tick_o
);
    logic [LED_W-1:0] cnt_w;
    disp_mode_e       mode_w;

    std_tick_divider #(
        .DIV_W    (DIV_W),
        .TICK_LOG2(TICK_LOG2)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .tick_o(tick_o)
    );

    std_ref_counter #(
        .CNT_W(LED_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick_i(tick_o),
        .cnt_o (cnt_w)
    );

    std_mode_toggle u_mode (
        .clk   (clk),
        .rst   (rst),
        .btn_i (mode_btn_i),
        .mode_o(mode_w)
    );

    std_led_mux #(
        .LED_W(LED_W)
    ) u_mux (
        .mode_i  (mode_w),
        .cnt_hi_i(cnt_w[LED_W-1:1]),
        .seed_i  (seed_flag_i),
        .reg_i   (reg_val_i),
        .led_o   (led_o)
    );

endmodule

// File: rtl/slow_tick_display_chk.sv
module slow_tick_display_chk #(
    parameter int TICK_LOG2 = 15,
    parameter int LED_W     = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             btn,
    input logic             tick,
    input logic [LED_W-1:0] cnt,
    input logic             mode,
    input logic             seed,
    input logic [LED_W-1:0] regv,
    input logic [LED_W-1:0] led
);
    localparam int GAP_W = TICK_LOG2 + 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'((1 << TICK_LOG2) - 1);

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || tick) gap_q <= '0;
        else             gap_q <= gap_q + GAP_W'(1);
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap_q == GAP_LAST)); // R1
    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == $past(cnt) + LED_W'(1))); // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt)); // R3
    AST_CLEAR: assert property (@(posedge clk)
        rst |=> (cnt == '0 && mode == 1'b0)); // R4
    AST_VIEW_CNT: assert property (@(posedge clk) disable iff (rst)
        mode |-> (led == {cnt[LED_W-1:1], seed})); // R5
    AST_VIEW_REG: assert property (@(posedge clk) disable iff (rst)
        !mode |-> (led == regv)); // R6
    AST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        $rose(btn) |=> (mode != $past(mode))); // R7
    AST_NO_STRAY_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        !$rose(btn) |=> $stable(mode)); // R7

endmodule

bind slow_tick_display slow_tick_display_chk #(
    .TICK_LOG2(TICK_LOG2),
    .LED_W    (LED_W)
) u_chk (
    .clk (clk),
    .rst (rst),
    .btn (mode_btn_i),
    .tick(tick_o),
    .cnt (cnt_w),
    .mode(mode_w),
    .seed(seed_flag_i),
    .regv(reg_val_i),
    .led (led_o)
);

// File: tb/tb_slow_tick_display.sv
module tb_slow_tick_display;
    localparam int CLK_PERIOD = 10;
    localparam int BIG_P      = 32768;
    localparam int SMALL_P    = 8;
    localparam int RUN_N      = 66000;

    logic       clk   = 1'b0;
    logic       rst   = 1'b1;
    logic       btn   = 1'b0;
    logic       btn_s = 1'b0;
    logic       seed  = 1'b1;
    logic [7:0] regv  = 8'hA5;
    logic [7:0] led, led_s;
    logic       tick, tick_s;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slow_tick_display dut (
        .clk(clk), .rst(rst), .mode_btn_i(btn), .seed_flag_i(seed),
        .reg_val_i(regv), .led_o(led), .tick_o(tick)
    );

    slow_tick_display #(.DIV_W(4), .TICK_LOG2(3), .LED_W(8)) dut_s (
        .clk(clk), .rst(rst), .mode_btn_i(btn_s), .seed_flag_i(seed),
        .reg_val_i(regv), .led_o(led_s), .tick_o(tick_s)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] cnt_view(input int c, input logic s);
        logic [31:0] t;
        t = c;
        return {t[7:1], s};
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        int  ticks_seen;
        bit  prev_tick;
        bit  s_cnt_mode;
        ticks_seen = 0;
        prev_tick  = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R8", "big led in reset", led, regv);
        chk("R8", "small led in reset", led_s, regv);
        chk("R8", "big tick in reset", tick, 0);
        chk("R8", "small tick in reset", tick_s, 0);
        rst = 1'b0;

        for (int n = 1; n <= RUN_N; n++) begin
            @(posedge clk);
            @(negedge clk);
            regv = 8'(n) ^ 8'h3C;
            seed = n[6];
            if (n == 2 || n == 2500 || n == 2700) btn_s = 1'b1;
            if (n == 10 || n == 2505 || n == 2705) btn_s = 1'b0;
            if (n == 40000) btn = 1'b1;
            if (n == 40050) btn = 1'b0;
            #1;
            // large divider: tick positions and width
            if (tick) begin
                ticks_seen++;
                chk("R1", "big tick position", n % BIG_P, BIG_P - 1);
                chk("R2", "big tick single cycle", prev_tick, 0);
            end
            prev_tick = tick;
            if (n == 32767 || n == 65535) chk("R1", "big tick expected", tick, 1);
            if (n == 32766 || n == 32768) chk("R2", "big tick neighbours", tick, 0);
            // large instance view
            if (n <= 40000) chk("R6", "big register view", led, regv);
            else            chk("R5", "big counter view", led, cnt_view(n / BIG_P, seed));
            // small instance sweep
            if (n <= 3000) begin
                chk("R1", "small tick", tick_s, (n % SMALL_P) == SMALL_P - 1);
                s_cnt_mode = (n >= 3 && n <= 2500) || (n >= 2701);
                if (s_cnt_mode)
                    chk("R3", "small counter view", led_s,
                        cnt_view((n / SMALL_P) % 256, seed));
                else
                    chk("R7", "small register view", led_s, regv);
                if (n == 2048) chk("R3", "wrap to zero", led_s[7:1], 0);
                if (n == 9) chk("R7", "held button no retoggle", led_s,
                                cnt_view(1, seed));
            end
        end
        chk("R1", "big tick count", ticks_seen, 2);

        // place reset exactly on a small-instance tick cycle
        seed = 1'b1;
        regv = 8'h5A;
        for (int k = 0; k < 16; k++) begin
            @(posedge clk);
            @(negedge clk);
            #1;
            if (tick_s) break;
        end
        chk("R4", "tick before clear", tick_s, 1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R4", "small view after clear", led_s, regv);
        chk("R4", "big view after clear", led, regv);
        rst   = 1'b0;
        btn_s = 1'b1;
        for (int n = 1; n <= 20; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n == 2) btn_s = 1'b0;
            #1;
            chk("R4", "divider restart", tick_s, (n % SMALL_P) == SMALL_P - 1);
            chk("R4", "counter restart", led_s, cnt_view(n / SMALL_P, seed));
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule